// File: doc/BRIEF.md
# Byte-Stream Frame Assembler with Header Checksum Gate

The block receives a byte stream, one byte for each cycle on which the input strobe is high, and groups a fixed number of bytes into a frame. A frame consists of header bytes, then payload bytes, then a single checksum byte. When the last byte of a frame arrives, the block compares the checksum byte with the XOR of the header bytes. If they agree, the whole frame is published on a wide output bus with a one-cycle valid pulse. If they disagree, a one-cycle bad-check pulse is raised instead and the frame is not published.

Capture never stops for the check. The byte that follows a frame's final byte, even on the very next cycle, is already byte 0 of the next frame. The published frame sits in a holding register, so it stays fixed while later bytes stream in, until the next frame that passes the check replaces it. The header accumulator starts fresh with every frame.

Top module: `frame_gate`

## Requirements
- R1: While reset (`rst_n` low) is applied and directly after it, `out_valid` and `bad_check` are low and `out_frame` is all zeros.
- R2: A byte is taken only on a rising clock edge where `in_valid` is high. Cycles with `in_valid` low do not advance the frame and change no output.
- R3: A frame is complete after exactly FRAME_BYTES = HDR_BYTES + PAY_BYTES + 1 accepted bytes (13 by default), and the next accepted byte starts a new frame.
- R4: In `out_frame`, accepted byte k of the frame sits at bits [8k+7:8k]. Bytes 0..HDR_BYTES-1 are the header, the following PAY_BYTES bytes are the payload, and the top byte is the checksum.
- R5: The check value is the bitwise XOR of the header bytes only. Payload bytes have no influence on the outcome.
- R6: When the checksum byte equals the check value, `out_valid` is high for exactly the one cycle after the clock edge that took the last byte, and in that cycle `out_frame` holds the frame.
- R7: When the checksum byte differs from the check value, `bad_check` is high for exactly that one cycle, `out_valid` stays low, and `out_frame` keeps the last frame that passed.
- R8: Every completed frame produces exactly one pulse, `out_valid` or `bad_check`, never both, and no pulse occurs without a completed frame.
- R9: The header accumulator restarts with each frame, so a failed frame has no effect on the verdict for the next one.
- R10: The next frame is captured while the previous one is checked. `out_frame` changes only on a cycle where `out_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Byte strobe; `in_byte` is taken when high |
| in_byte | input | BYTE_W | Incoming byte |
| out_valid | output | 1 | One-cycle pulse: a frame passed the check |
| out_frame | output | FRAME_BYTES*BYTE_W | Last frame that passed, byte 0 in the low bits |
| bad_check | output | 1 | One-cycle pulse: checksum mismatch, frame dropped |

## Verification
Two cases are the hardest to reach from the ports. The first is a frame that completes on the cycle right before the next frame's first byte, while the verdict for the first frame is still in flight. The second is a failed frame followed immediately by a good one, which shows that the accumulator and the held output do not carry over between frames. The stimulus sends runs of frames back to back with no idle cycle between them. It mixes in frames with random idle gaps and frames whose checksum is corrupted. It also sends a frame whose checksum equals the XOR over header and payload together; only a payload-blind check rejects that frame.

// File: rtl/fgate_pkg.sv
package fgate_pkg;
   // Section of the frame that the current byte slot belongs to.
   typedef enum logic [1:0] {
      SEG_HEAD = 2'd0,
      SEG_BODY = 2'd1,
      SEG_SUM  = 2'd2
   } seg_e;
endpackage

// File: rtl/fg_capture.sv
module fg_capture
   import fgate_pkg::*;
#(
   parameter  int BYTE_W      = 8,
   parameter  int HDR_BYTES   = 4,
   parameter  int PAY_BYTES   = 8,
   localparam int FRAME_BYTES = HDR_BYTES + PAY_BYTES + 1,
   localparam int IDX_W       = $clog2(FRAME_BYTES)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          in_valid,
   input  logic [BYTE_W-1:0]             in_byte,
   output logic [IDX_W-1:0]              idx,
   output seg_e                          seg,
   output logic                          last_take,
   output logic [FRAME_BYTES*BYTE_W-1:0] frame_now
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BYTES - 1);
   localparam logic [IDX_W-1:0] HDR_END  = IDX_W'(HDR_BYTES);

   logic [IDX_W-1:0] idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else if (in_valid) begin
         idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + IDX_W'(1);
      end
   end

   always_comb begin
      if (idx_q < HDR_END)        seg = SEG_HEAD;
      else if (idx_q == LAST_IDX) seg = SEG_SUM;
      else                        seg = SEG_BODY;
   end

   assign idx       = idx_q;
   assign last_take = in_valid && (idx_q == LAST_IDX);

   // One storage slot for every byte except the checksum, which is used
   // straight from the input on the completing cycle.
   for (genvar g = 0; g < FRAME_BYTES - 1; g++) begin : g_slot
      logic [BYTE_W-1:0] slot_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            slot_q <= '0;
         end else if (in_valid && (idx_q == IDX_W'(g))) begin
            slot_q <= in_byte;
         end
      end
      assign frame_now[g*BYTE_W +: BYTE_W] = slot_q;
   end

   assign frame_now[(FRAME_BYTES-1)*BYTE_W +: BYTE_W] = in_byte;
endmodule

// File: rtl/fg_hdr_xor.sv
module fg_hdr_xor
   import fgate_pkg::*;
#(
   parameter  int BYTE_W      = 8,
   parameter  int HDR_BYTES   = 4,
   parameter  int PAY_BYTES   = 8,
   localparam int FRAME_BYTES = HDR_BYTES + PAY_BYTES + 1,
   localparam int IDX_W       = $clog2(FRAME_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [BYTE_W-1:0] in_byte,
   input  logic [IDX_W-1:0]  idx,
   input  seg_e              seg,
   output logic [BYTE_W-1:0] hdr_sum
);
   logic [BYTE_W-1:0] acc_q;

   // Slot 0 overwrites instead of folding in, so no frame inherits a
   // previous one's residue.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (in_valid && (seg == SEG_HEAD)) begin
         acc_q <= ((idx == '0) ? '0 : acc_q) ^ in_byte;
      end
   end

   assign hdr_sum = acc_q;
endmodule

// File: rtl/fg_forward.sv
module fg_forward #(
   parameter  int BYTE_W      = 8,
   parameter  int HDR_BYTES   = 4,
   parameter  int PAY_BYTES   = 8,
   localparam int FRAME_BYTES = HDR_BYTES + PAY_BYTES + 1,
   localparam int FRAME_W     = FRAME_BYTES * BYTE_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               last_take,
   input  logic [BYTE_W-1:0]  hdr_sum,
   input  logic [FRAME_W-1:0] frame_now,
   output logic               out_valid,
   output logic               bad_check,
   output logic [FRAME_W-1:0] out_frame
);
   logic               fire_q;
   logic               match_q;
   logic [FRAME_W-1:0] hold_q;
   logic               sum_ok;

   assign sum_ok = (frame_now[FRAME_W-1 -: BYTE_W] == hdr_sum);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fire_q  <= 1'b0;
         match_q <= 1'b0;
         hold_q  <= '0;
      end else begin
         fire_q  <= last_take;
         match_q <= sum_ok;
         if (last_take && sum_ok) begin
            hold_q <= frame_now;
         end
      end
   end

   assign out_valid = fire_q & match_q;
   assign bad_check = fire_q & ~match_q;
   assign out_frame = hold_q;
endmodule

// File: rtl/frame_gate.sv
module frame_gate
   import fgate_pkg::*;
#(
   parameter  int BYTE_W      = 8,
   parameter  int HDR_BYTES   = 4,
   parameter  int PAY_BYTES   = 8,
   localparam int FRAME_BYTES = HDR_BYTES + PAY_BYTES + 1,
   localparam int FRAME_W     = FRAME_BYTES * BYTE_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [BYTE_W-1:0]  in_byte,
   output logic               out_valid,
   output logic [FRAME_W-1:0] out_frame,
   output logic               bad_check
);
   localparam int IDX_W = $clog2(FRAME_BYTES);

   if (BYTE_W < 1) begin : g_bad_width
      $error("frame_gate: BYTE_W must be at least 1");
   end
   if (HDR_BYTES < 1) begin : g_bad_hdr
      $error("frame_gate: HDR_BYTES must be at least 1");
   end
   if (PAY_BYTES < 0) begin : g_bad_pay
      $error("frame_gate: PAY_BYTES must not be negative");
   end

   logic [IDX_W-1:0]   idx;
   seg_e               seg;
   logic               last_take;
   logic [FRAME_W-1:0] frame_now;
   logic [BYTE_W-1:0]  hdr_sum;

   fg_capture #(
      .BYTE_W(BYTE_W), .HDR_BYTES(HDR_BYTES), .PAY_BYTES(PAY_BYTES)
   ) u_capture (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
      .idx(idx), .seg(seg), .last_take(last_take), .frame_now(frame_now)
   );

   fg_hdr_xor #(
      .BYTE_W(BYTE_W), .HDR_BYTES(HDR_BYTES), .PAY_BYTES(PAY_BYTES)
   ) u_hdr_xor (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
      .idx(idx), .seg(seg), .hdr_sum(hdr_sum)
   );

   fg_forward #(
      .BYTE_W(BYTE_W), .HDR_BYTES(HDR_BYTES), .PAY_BYTES(PAY_BYTES)
   ) u_forward (
      .clk(clk), .rst_n(rst_n), .last_take(last_take), .hdr_sum(hdr_sum),
      .frame_now(frame_now), .out_valid(out_valid), .bad_check(bad_check),
      .out_frame(out_frame)
   );
endmodule

// File: rtl/frame_gate_chk.sv
module frame_gate_chk #(
   parameter  int BYTE_W      = 8,
   parameter  int HDR_BYTES   = 4,
   parameter  int PAY_BYTES   = 8,
   localparam int FRAME_BYTES = HDR_BYTES + PAY_BYTES + 1,
   localparam int FRAME_W     = FRAME_BYTES * BYTE_W,
   localparam int IDX_W       = $clog2(FRAME_BYTES)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic               out_valid,
   input logic               bad_check,
   input logic [FRAME_W-1:0] out_frame
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BYTES - 1);

   logic [IDX_W-1:0] cnt_q;
   logic             due_q;

   // Independent byte counter: marks the cycle a verdict is owed.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         due_q <= 1'b0;
      end else begin
         due_q <= in_valid && (cnt_q == LAST_IDX);
         if (in_valid) cnt_q <= (cnt_q == LAST_IDX) ? '0 : cnt_q + IDX_W'(1);
      end
   end

   function automatic logic [BYTE_W-1:0] head_xor(input logic [FRAME_W-1:0] f);
      logic [BYTE_W-1:0] r;
      r = '0;
      for (int k = 0; k < HDR_BYTES; k++) r ^= f[k*BYTE_W +: BYTE_W];
      return r;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_quiet_R1: assert (!out_valid && !bad_check && (out_frame == '0))
            else $error("outputs not at reset values");
      end
   end

   assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({out_valid, bad_check}));

   assert_one_per_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
      due_q == (out_valid || bad_check));

   assert_pass_consistent_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_frame[FRAME_W-1 -: BYTE_W] == head_xor(out_frame)));

   assert_drop_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
      bad_check |-> $stable(out_frame));

   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> $stable(out_frame));
endmodule

bind frame_gate frame_gate_chk #(
   .BYTE_W(BYTE_W), .HDR_BYTES(HDR_BYTES), .PAY_BYTES(PAY_BYTES)
) u_frame_gate_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
   .bad_check(bad_check), .out_frame(out_frame)
);

// File: tb/frame_gate_bench.sv
module frame_gate_bench;
   localparam int BW = 8;
   localparam int HB = 4;
   localparam int PB = 8;
   localparam int FB = HB + PB + 1;
   localparam int FW = FB * BW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [BW-1:0] in_byte = '0;
   logic          out_valid;
   logic          bad_check;
   logic [FW-1:0] out_frame;

   always #5 clk = ~clk;

   frame_gate u_frame_gate (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
      .out_valid(out_valid), .out_frame(out_frame), .bad_check(bad_check)
   );

   typedef struct packed {
      logic          good;
      int            cyc;
      logic [FW-1:0] frame;
   } exp_t;

   exp_t          q[$];
   int            checks = 0;
   int            fails = 0;
   int            cyc = 0;
   bit            finished = 1'b0;
   logic [FW-1:0] last_good = '0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [FW-1:0] act, input logic [FW-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [BW-1:0] hx(input logic [FW-1:0] f);
      logic [BW-1:0] r;
      r = '0;
      for (int k = 0; k < HB; k++) r ^= f[k*BW +: BW];
      return r;
   endfunction

   // Frame with random header/payload and a correct checksum.
   function automatic logic [FW-1:0] make_good();
      logic [FW-1:0] f;
      for (int k = 0; k < FB - 1; k++) f[k*BW +: BW] = BW'($urandom);
      f[FW-1 -: BW] = hx(f);
      return f;
   endfunction

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_byte  = BW'($urandom);
      end
   endtask

   // Driver: pushes the expected verdict when the last byte is presented.
   task automatic send(input logic [FW-1:0] f, input int max_gap);
      exp_t e;
      for (int k = 0; k < FB; k++) begin
         if (max_gap > 0) idle($urandom_range(max_gap, 0));
         @(negedge clk);
         in_valid = 1'b1;
         in_byte  = f[k*BW +: BW];
         if (k == FB - 1) begin
            e.good  = (hx(f) == f[FW-1 -: BW]);
            e.cyc   = cyc;
            e.frame = f;
            q.push_back(e);
         end
      end
   endtask

   // Monitor / scoreboard.
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (out_valid || bad_check) begin
            if (q.size() == 0) begin
               check(1'b0, "R8", "pulse without frame", FW'(out_valid), '0);
            end else begin
               exp_t e;
               e = q.pop_front();
               check(!(out_valid && bad_check), "R8", "both pulses", FW'({out_valid, bad_check}), FW'(0));
               check(cyc == e.cyc + 1, "R6", "verdict cycle", FW'(cyc), FW'(e.cyc + 1));
               if (e.good) begin
                  check(out_valid, "R6", "expected out_valid", FW'(out_valid), FW'(1));
                  check(out_frame == e.frame, "R4", "forwarded frame", out_frame, e.frame);
                  last_good = e.frame;
               end else begin
                  check(bad_check, "R7", "expected bad_check", FW'(bad_check), FW'(1));
                  check(out_frame == last_good, "R7", "dropped frame leaked", out_frame, last_good);
               end
            end
         end else begin
            check(out_frame == last_good, "R10", "held frame moved", out_frame, last_good);
         end
      end
   end

   initial begin
      logic [FW-1:0] f;
      repeat (3) @(negedge clk);
      check(!out_valid && !bad_check, "R1", "pulses in reset", FW'({out_valid, bad_check}), '0);
      check(out_frame == '0, "R1", "frame in reset", out_frame, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!out_valid && !bad_check && out_frame == '0, "R1", "after reset", out_frame, '0);

      // R6/R4: plain good frames with no gaps.
      for (int n = 0; n < 4; n++) send(make_good(), 0);
      idle(3);

      // R2: random idle gaps between bytes.
      for (int n = 0; n < 6; n++) send(make_good(), 3);
      idle(4);

      // R7: corrupted checksums.
      for (int n = 0; n < 4; n++) begin
         f = make_good();
         f[FW-1 -: BW] = f[FW-1 -: BW] ^ BW'(1 << n);
         send(f, 1);
      end
      idle(2);

      // R5: payload changes, header fixed: still good.
      f = make_good();
      send(f, 0);
      f[HB*BW +: BW] = f[HB*BW +: BW] ^ 8'hA5;
      send(f, 0);
      // R5: checksum over header plus payload must be rejected.
      f[HB*BW +: BW] = f[HB*BW +: BW] | 8'h01;
      f[(HB+1)*BW +: BW] = 8'h00;
      begin
         logic [BW-1:0] all_x;
         all_x = hx(f);
         for (int k = HB; k < FB - 1; k++) all_x ^= f[k*BW +: BW];
         f[FW-1 -: BW] = all_x;
      end
      send(f, 0);

      // R9/R3: bad then good, back to back, repeated.
      for (int n = 0; n < 8; n++) begin
         f = make_good();
         if (n[0] == 1'b0) f[FW-1 -: BW] = ~f[FW-1 -: BW];
         send(f, 0);
      end
      idle(5);

      // R3/R8: every frame got exactly one verdict.
      check(q.size() == 0, "R8", "frames without verdict", FW'(q.size()), '0);

      // R2: idle bytes with in_valid low change nothing.
      idle(20);
      check(!out_valid && !bad_check, "R2", "idle produced pulse", FW'({out_valid, bad_check}), '0);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog R3 run did not finish actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule